// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a 32-bit processor core in which every instruction is fetched, decoded, executed and retired in a single clock period. It runs a small load/store instruction subset:
- register-to-register add, subtract, AND, OR and signed set-less-than;
- add-immediate;
- word load and word store;
- branch-if-equal;
- absolute jump.

The core holds the program counter, a 32-entry register file, an ALU with a carry-based unsigned overflow flag, a sign extender, and small word-addressed instruction and data memories. A main decoder turns the 6-bit opcode into a bundle of datapath strobes. A second decoder picks the ALU function from a 2-bit ALU operation code and the funct field.

The instruction memory is loaded through a simple write port while the core is held in reset. After reset is released, the core starts at address 0. Each retiring instruction is visible on a set of trace outputs:
- the current PC and instruction word;
- the register write-back enable, destination and data;
- the store enable, address and data;
- the ALU overflow flag.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the PC to 0 on the next rising clock edge. The PC stays at 0 for as long as reset is held.
- R2: Add, subtract, AND, OR, set-less-than, add-immediate, load, store, a branch that is not taken, and any unknown opcode all advance the PC by 4.
- R3: Opcode 000000 selects register-format instructions. The funct field (bits 5-0) selects the operation: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 101010 signed set-less-than (result 1 or 0). The result is written to the register named by bits 15-11. Source registers come from bits 25-21 and 20-16.
- R4: Opcode 001000 (add-immediate) writes, to the register named by bits 20-16, the value of the register named by bits 25-21 plus the sign-extended bits 15-0. It does not touch data memory.
- R5: Opcode 101011 stores, and opcode 100011 loads, one 32-bit word at the address (register at bits 25-21) plus (sign-extended bits 15-0). Memory is indexed by address bits above bit 1. A load returns the word written by an earlier store to the same address. A load writes the register named by bits 20-16.
- R6: Register 0 always reads as zero, even after an instruction names it as its destination.
- R7: Opcode 000100 branches when the two source registers are equal. The target is PC+4 plus the sign-extended immediate shifted left by 2. When the registers differ, the PC advances by 4. A branch writes neither a register nor memory.
- R8: Opcode 000010 jumps to the address formed from bits 31-28 of PC+4, followed by instruction bits 25-0, followed by two zero bits.
- R9: `aluOvf` is the carry out of bit 31 whenever the ALU adds. This covers add, add-immediate, and load/store address generation. It is 0 for subtract, AND, OR and set-less-than.
- R10: Any opcode outside the six listed above writes no register, performs no store, and does not branch or jump.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the PC |
| progWe | input | 1 | Instruction memory write enable |
| progAddr | input | log2(IMEM_WORDS) | Instruction memory word index |
| progData | input | 32 | Instruction word to write |
| pcOut | output | 32 | Address of the instruction executing this cycle |
| instrOut | output | 32 | Instruction word executing this cycle |
| wbEn | output | 1 | Register write strobe for this instruction |
| wbAddr | output | 5 | Destination register index |
| wbData | output | 32 | Value written to the register file |
| stEn | output | 1 | Data memory store strobe |
| stAddr | output | 32 | Byte address of the store or load |
| stData | output | 32 | Word being stored |
| aluOvf | output | 1 | Carry out of bit 31 on ALU additions |

## Verification
The hardest behaviour to reach from the ports is control flow that depends on earlier state. Two cases matter most:
- A taken branch needs equal register values that previous instructions have built.
- A load result only proves the memory path if an earlier store to the same word came first.

The stimulus therefore runs one preloaded program that sets up these conditions before it exercises them. Along the way it covers:
- a taken branch and a not-taken branch;
- a jump over skipped words that would corrupt a register if they executed;
- a store through a negative offset, read back by a later load;
- a write to register 0, followed by a read of register 0;
- an unknown opcode;
- a branch to itself, which parks the PC.

A mid-run reset then checks that execution restarts at address 0.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int XLEN  = 32;
  localparam int REG_N = 32;
  localparam int RA_W  = $clog2(REG_N);

  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_ADDI  = 6'b001000;
  localparam logic [5:0] OPC_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } aluOp_e;

  typedef enum logic [2:0] {
    FN_SEL_ADD,
    FN_SEL_SUB,
    FN_SEL_AND,
    FN_SEL_OR,
    FN_SEL_SLT
  } aluFn_e;

  typedef struct packed {
    logic   regDst;
    logic   aluSrc;
    logic   memToReg;
    logic   regWrite;
    logic   memRead;
    logic   memWrite;
    logic   branch;
    logic   jump;
    aluOp_e aluOp;
  } ctrl_t;

endpackage

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluFn_e       fn,
  output logic [W-1:0] result,
  output logic         zero,
  output logic         carryOut
);

  logic [W:0] sumWide;

  assign sumWide = {1'b0, opA} + {1'b0, opB};

  always_comb begin
    carryOut = 1'b0;
    unique case (fn)
      FN_SEL_ADD: begin
        result   = sumWide[W-1:0];
        carryOut = sumWide[W];
      end
      FN_SEL_SUB: result = opA - opB;
      FN_SEL_AND: result = opA & opB;
      FN_SEL_OR:  result = opA | opB;
      FN_SEL_SLT: result = {{(W-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default:    result = sumWide[W-1:0];
    endcase
  end

  assign zero = (result == '0);

endmodule

// File: rtl/sc_control.sv
module sc_control
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output aluFn_e     aluFn
);

  // Main decoder: opcode to datapath strobes
  always_comb begin
    ctrl = '0;
    case (opcode)
      OPC_RTYPE: begin
        ctrl.regDst   = 1'b1;
        ctrl.regWrite = 1'b1;
        ctrl.aluOp    = AOP_FUNCT;
      end
      OPC_LOAD: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.memToReg = 1'b1;
        ctrl.regWrite = 1'b1;
        ctrl.memRead  = 1'b1;
      end
      OPC_STORE: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.memWrite = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.aluOp  = AOP_SUB;
      end
      OPC_ADDI: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.regWrite = 1'b1;
      end
      OPC_JUMP: ctrl.jump = 1'b1;
      default: ctrl = '0;
    endcase
  end

  // ALU decoder: ALU op code plus funct field to ALU function
  always_comb begin
    case (ctrl.aluOp)
      AOP_ADD: aluFn = FN_SEL_ADD;
      AOP_SUB: aluFn = FN_SEL_SUB;
      default: begin
        case (funct)
          FN_SUB:  aluFn = FN_SEL_SUB;
          FN_AND:  aluFn = FN_SEL_AND;
          FN_OR:   aluFn = FN_SEL_OR;
          FN_SLT:  aluFn = FN_SEL_SLT;
          default: aluFn = FN_SEL_ADD;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IA_W = $clog2(IMEM_WORDS),
  localparam int DA_W = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  ctrl_t           ctrl,
  input  aluFn_e          aluFn,
  input  logic            progWe,
  input  logic [IA_W-1:0] progAddr,
  input  logic [XLEN-1:0] progData,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  output logic [XLEN-1:0] pcOut,
  output logic [XLEN-1:0] instrOut,
  output logic            wbEn,
  output logic [RA_W-1:0] wbAddr,
  output logic [XLEN-1:0] wbData,
  output logic            stEn,
  output logic [XLEN-1:0] stAddr,
  output logic [XLEN-1:0] stData,
  output logic            aluOvf
);

  logic [XLEN-1:0] pc, pcNext, pcPlus4, brTarget, jmpTarget;
  logic [XLEN-1:0] instr, immExt, rsData, rtData, aluB, aluRes, loadData;
  logic [RA_W-1:0] rsIdx, rtIdx, rdIdx, dstIdx;
  logic            aluZero, aluCarry, brTaken;

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];
  logic [XLEN-1:0] rf   [REG_N];

  // Instruction memory: written only through the program-load port
  always_ff @(posedge clk) begin
    if (progWe) imem[progAddr] <= progData;
  end

  assign instr  = imem[pc[IA_W+1:2]];
  assign opcode = instr[31:26];
  assign funct  = instr[5:0];
  assign rsIdx  = instr[25:21];
  assign rtIdx  = instr[20:16];
  assign rdIdx  = instr[15:11];
  assign immExt = {{(XLEN-16){instr[15]}}, instr[15:0]};

  // Register file: combinational read, index 0 forced to zero
  assign rsData = (rsIdx == '0) ? '0 : rf[rsIdx];
  assign rtData = (rtIdx == '0) ? '0 : rf[rtIdx];
  assign dstIdx = ctrl.regDst ? rdIdx : rtIdx;

  always_ff @(posedge clk) begin
    if (ctrl.regWrite && dstIdx != '0) rf[dstIdx] <= wbData;
  end

  assign aluB = ctrl.aluSrc ? immExt : rtData;

  sc_alu #(.W(XLEN)) u_alu (
    .opA      (rsData),
    .opB      (aluB),
    .fn       (aluFn),
    .result   (aluRes),
    .zero     (aluZero),
    .carryOut (aluCarry)
  );

  // Data memory: word indexed by address bits above bit 1
  always_ff @(posedge clk) begin
    if (ctrl.memWrite) dmem[aluRes[DA_W+1:2]] <= rtData;
  end

  assign loadData = ctrl.memRead ? dmem[aluRes[DA_W+1:2]] : '0;
  assign wbData   = ctrl.memToReg ? loadData : aluRes;

  // Next PC selection
  assign pcPlus4   = pc + XLEN'(4);
  assign brTarget  = pcPlus4 + {immExt[XLEN-3:0], 2'b00};
  assign jmpTarget = {pcPlus4[XLEN-1:XLEN-4], instr[25:0], 2'b00};
  assign brTaken   = ctrl.branch & aluZero;

  always_comb begin
    if (ctrl.jump)   pcNext = jmpTarget;
    else if (brTaken) pcNext = brTarget;
    else             pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  assign pcOut    = pc;
  assign instrOut = instr;
  assign wbEn     = ctrl.regWrite;
  assign wbAddr   = dstIdx;
  assign stEn     = ctrl.memWrite;
  assign stAddr   = aluRes;
  assign stData   = rtData;
  assign aluOvf   = aluCarry;

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IA_W = $clog2(IMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            progWe,
  input  logic [IA_W-1:0] progAddr,
  input  logic [31:0]     progData,
  output logic [31:0]     pcOut,
  output logic [31:0]     instrOut,
  output logic            wbEn,
  output logic [4:0]      wbAddr,
  output logic [31:0]     wbData,
  output logic            stEn,
  output logic [31:0]     stAddr,
  output logic [31:0]     stData,
  output logic            aluOvf
);

  ctrl_t      ctrl;
  aluFn_e     aluFn;
  logic [5:0] opcode, funct;

  sc_control u_ctrl (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl),
    .aluFn  (aluFn)
  );

  sc_datapath #(
    .IMEM_WORDS (IMEM_WORDS),
    .DMEM_WORDS (DMEM_WORDS)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .aluFn    (aluFn),
    .progWe   (progWe),
    .progAddr (progAddr),
    .progData (progData),
    .opcode   (opcode),
    .funct    (funct),
    .pcOut    (pcOut),
    .instrOut (instrOut),
    .wbEn     (wbEn),
    .wbAddr   (wbAddr),
    .wbData   (wbData),
    .stEn     (stEn),
    .stAddr   (stAddr),
    .stData   (stData),
    .aluOvf   (aluOvf)
  );

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pcOut,
  input logic [31:0] instrOut,
  input logic        wbEn,
  input logic        stEn,
  input logic        aluOvf
);

  logic [5:0]  opc;
  logic [5:0]  fn;
  logic [31:0] seqPc;
  logic        knownOpc, seqOpc;

  assign opc      = instrOut[31:26];
  assign fn       = instrOut[5:0];
  assign seqPc    = pcOut + 32'd4;
  assign seqOpc   = (opc == 6'b000000) || (opc == 6'b100011) ||
                    (opc == 6'b101011) || (opc == 6'b001000);
  assign knownOpc = seqOpc || (opc == 6'b000100) || (opc == 6'b000010);

  // R1: leaving reset, execution starts at address 0
  a_r1_reset_pc: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pcOut == 32'd0);

  // R2: straight-line instructions step the PC by 4
  a_r2_step_four: assert property (@(posedge clk) disable iff (rst)
    seqOpc |=> pcOut == $past(seqPc));

  // R8: jump target built from upper PC+4 bits and the 26-bit field
  a_r8_jump_target: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'b000010) |=> pcOut == {$past(seqPc[31:28]), $past(instrOut[25:0]), 2'b00});

  // R7: a branch never writes a register or memory
  a_r7_branch_quiet: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'b000100) |-> !wbEn && !stEn);

  // R5: a store raises the store strobe and no register write
  a_r5_store_strobes: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'b101011) |-> stEn && !wbEn);

  // R9: logic, compare and subtract never raise the carry flag
  a_r9_no_carry_nonadd: assert property (@(posedge clk) disable iff (rst)
    ((opc == 6'b000000) && (fn != 6'b100000)) |-> !aluOvf);

  // R10: unknown opcodes write nothing and fall through
  a_r10_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
    !knownOpc |-> !wbEn && !stEn);

  a_r10_unknown_step: assert property (@(posedge clk) disable iff (rst)
    !knownOpc |=> pcOut == $past(seqPc));

endmodule

bind sc_core sc_core_chk u_chk (.*);

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;

  localparam int IMEM_WORDS = 64;
  localparam int IA_W       = $clog2(IMEM_WORDS);
  localparam int PROG_N     = 28;
  localparam int VEC_N      = 26;

  function automatic logic [31:0] encR(logic [4:0] rs, logic [4:0] rt,
                                       logic [4:0] rd, logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] encI(logic [5:0] op, logic [4:0] rs,
                                       logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] encJ(logic [25:0] a);
    return {6'h02, a};
  endfunction

  typedef struct packed {
    logic [31:0] pc;
    logic        wb;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic        st;
    logic [31:0] sa;
    logic [31:0] sd;
    logic        ovf;
  } exp_t;

  function automatic exp_t ev(logic [31:0] pc, logic wb, logic [4:0] wa,
                              logic [31:0] wd, logic st, logic [31:0] sa,
                              logic [31:0] sd, logic ovf);
    return '{pc, wb, wa, wd, st, sa, sd, ovf};
  endfunction

  localparam logic [31:0] PROG [PROG_N] = '{
    encI(6'h08, 5'd0, 5'd1, 16'd5),          // 0  addi r1 = 5
    encI(6'h08, 5'd0, 5'd2, 16'hFFFD),       // 1  addi r2 = -3
    encR(5'd1, 5'd2, 5'd3, 6'h20),           // 2  add r3
    encR(5'd2, 5'd1, 5'd4, 6'h22),           // 3  sub r4
    encR(5'd1, 5'd2, 5'd5, 6'h24),           // 4  and r5
    encR(5'd1, 5'd2, 5'd6, 6'h25),           // 5  or r6
    encR(5'd2, 5'd1, 5'd7, 6'h2A),           // 6  slt r7 (true)
    encR(5'd1, 5'd2, 5'd8, 6'h2A),           // 7  slt r8 (false)
    encI(6'h2B, 5'd0, 5'd4, 16'd8),          // 8  sw r4, 8(r0)
    encI(6'h23, 5'd0, 5'd9, 16'd8),          // 9  lw r9, 8(r0)
    encR(5'd1, 5'd1, 5'd0, 6'h20),           // 10 add r0 (discarded)
    encR(5'd0, 5'd1, 5'd10, 6'h20),          // 11 add r10 = r0 + r1
    encI(6'h04, 5'd1, 5'd2, 16'd5),          // 12 beq not taken
    encI(6'h04, 5'd3, 5'd3, 16'd2),          // 13 beq taken -> 16
    encI(6'h08, 5'd0, 5'd11, 16'd99),        // 14 skipped
    encI(6'h08, 5'd0, 5'd11, 16'd98),        // 15 skipped
    encJ(26'd19),                            // 16 j 19
    encI(6'h08, 5'd0, 5'd11, 16'd97),        // 17 skipped
    encI(6'h08, 5'd0, 5'd11, 16'd96),        // 18 skipped
    encI(6'h08, 5'd0, 5'd12, 16'h7FFF),      // 19 addi r12
    encI(6'h08, 5'd12, 5'd13, 16'h8000),     // 20 addi r13 = r12 - 32768
    encI(6'h08, 5'd0, 5'd15, 16'd16),        // 21 addi r15 = 16
    encI(6'h2B, 5'd15, 5'd3, 16'hFFFC),      // 22 sw r3, -4(r15)
    encI(6'h23, 5'd0, 5'd16, 16'd12),        // 23 lw r16, 12(r0)
    encI(6'h08, 5'd0, 5'd17, 16'hFFFF),      // 24 addi r17 = -1
    encR(5'd17, 5'd1, 5'd18, 6'h20),         // 25 add r18 (carry)
    32'hFC00_0000,                           // 26 unknown opcode
    encI(6'h04, 5'd0, 5'd0, 16'hFFFF)        // 27 beq to self
  };

  localparam exp_t VEC [VEC_N] = '{
    ev(32'd0,   1, 5'd1,  32'd5,         0, 0,      0,            0),
    ev(32'd4,   1, 5'd2,  32'hFFFFFFFD,  0, 0,      0,            0),
    ev(32'd8,   1, 5'd3,  32'd2,         0, 0,      0,            1),
    ev(32'd12,  1, 5'd4,  32'hFFFFFFF8,  0, 0,      0,            0),
    ev(32'd16,  1, 5'd5,  32'd5,         0, 0,      0,            0),
    ev(32'd20,  1, 5'd6,  32'hFFFFFFFD,  0, 0,      0,            0),
    ev(32'd24,  1, 5'd7,  32'd1,         0, 0,      0,            0),
    ev(32'd28,  1, 5'd8,  32'd0,         0, 0,      0,            0),
    ev(32'd32,  0, 5'd0,  32'd0,         1, 32'd8,  32'hFFFFFFF8, 0),
    ev(32'd36,  1, 5'd9,  32'hFFFFFFF8,  0, 0,      0,            0),
    ev(32'd40,  1, 5'd0,  32'd10,        0, 0,      0,            0),
    ev(32'd44,  1, 5'd10, 32'd5,         0, 0,      0,            0),
    ev(32'd48,  0, 5'd0,  32'd0,         0, 0,      0,            0),
    ev(32'd52,  0, 5'd0,  32'd0,         0, 0,      0,            0),
    ev(32'd64,  0, 5'd0,  32'd0,         0, 0,      0,            0),
    ev(32'd76,  1, 5'd12, 32'h00007FFF,  0, 0,      0,            0),
    ev(32'd80,  1, 5'd13, 32'hFFFFFFFF,  0, 0,      0,            0),
    ev(32'd84,  1, 5'd15, 32'd16,        0, 0,      0,            0),
    ev(32'd88,  0, 5'd0,  32'd0,         1, 32'd12, 32'd2,        1),
    ev(32'd92,  1, 5'd16, 32'd2,         0, 0,      0,            0),
    ev(32'd96,  1, 5'd17, 32'hFFFFFFFF,  0, 0,      0,            0),
    ev(32'd100, 1, 5'd18, 32'd4,         0, 0,      0,            1),
    ev(32'd104, 0, 5'd0,  32'd0,         0, 0,      0,            0),
    ev(32'd108, 0, 5'd0,  32'd0,         0, 0,      0,            0),
    ev(32'd108, 0, 5'd0,  32'd0,         0, 0,      0,            0),
    ev(32'd108, 0, 5'd0,  32'd0,         0, 0,      0,            0)
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            progWe = 1'b0;
  logic [IA_W-1:0] progAddr = '0;
  logic [31:0]     progData = '0;
  logic [31:0]     pcOut, instrOut, wbData, stAddr, stData;
  logic [4:0]      wbAddr;
  logic            wbEn, stEn, aluOvf;

  int nChk  = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  sc_core #(.IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(64)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .progWe   (progWe),
    .progAddr (progAddr),
    .progData (progData),
    .pcOut    (pcOut),
    .instrOut (instrOut),
    .wbEn     (wbEn),
    .wbAddr   (wbAddr),
    .wbData   (wbData),
    .stEn     (stEn),
    .stAddr   (stAddr),
    .stData   (stData),
    .aluOvf   (aluOvf)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tagOf(logic [31:0] ins, logic [4:0] wa);
    case (ins[31:26])
      6'h00:        return (wa == 5'd0) ? "R6 reg0 write" : "R3 rtype";
      6'h08:        return "R4 addi";
      6'h23, 6'h2B: return "R5 load/store";
      6'h04:        return "R7 branch";
      6'h02:        return "R8 jump";
      default:      return "R10 unknown opcode";
    endcase
  endfunction

  task automatic checkRow(int i);
    string t;
    t = tagOf(instrOut, VEC[i].wa);
    chk($sformatf("R2 pc row %0d", i), pcOut, VEC[i].pc);
    chk($sformatf("%s wbEn row %0d", t, i), {31'd0, wbEn}, {31'd0, VEC[i].wb});
    if (VEC[i].wb) begin
      chk($sformatf("%s wbAddr row %0d", t, i), {27'd0, wbAddr}, {27'd0, VEC[i].wa});
      chk($sformatf("%s wbData row %0d", t, i), wbData, VEC[i].wd);
    end
    chk($sformatf("%s stEn row %0d", t, i), {31'd0, stEn}, {31'd0, VEC[i].st});
    if (VEC[i].st) begin
      chk($sformatf("R5 stAddr row %0d", i), stAddr, VEC[i].sa);
      chk($sformatf("R5 stData row %0d", i), stData, VEC[i].sd);
    end
    chk($sformatf("R9 ovf row %0d", i), {31'd0, aluOvf}, {31'd0, VEC[i].ovf});
  endtask

  initial begin
    // Load the program while reset holds the PC
    for (int k = 0; k < PROG_N; k++) begin
      @(negedge clk);
      progWe   = 1'b1;
      progAddr = IA_W'(k);
      progData = PROG[k];
    end
    @(negedge clk);
    progWe = 1'b0;
    @(negedge clk);
    chk("R1 pc held in reset", pcOut, 32'd0);

    // Walk the program, one retired instruction per cycle
    rst = 1'b0;
    #1;
    for (int i = 0; i < VEC_N; i++) begin
      if (i > 0) begin
        @(negedge clk);
        #1;
      end
      checkRow(i);
    end

    // Reset in the middle of execution
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 pc after mid-run reset", pcOut, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 restart at word 0", instrOut, PROG[0]);
    chk("R4 restart addi result", wbData, 32'd5);
    @(negedge clk);
    #1;
    chk("R2 step after restart", pcOut, 32'd4);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    #2_000_000;
    nChk++;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule